// File: doc/BRIEF.md
# External DMA Request Handshake Sequencer

This block serves one DMA channel. It watches a transfer request line driven by an outside device and decides when each bus transfer may begin. When it accepts a request it raises a one-cycle accepted strobe. For every transfer it drives an acknowledge toward the device. It hands each transfer to a separate bus-cycle engine with a one-cycle start pulse. The engine reports back with a read-half-done pulse, used only for two-address transfers, and a transfer-done pulse.

Detection can respond to the request level or to a rising transition. Operation can be burst or cycle-steal. Each transfer is either a one-address transfer or a two-address transfer with a read half and a write half. Three rules shape the run of transfers. With edge detection in burst mode, one accepted request runs the whole programmed count. With level detection, the request is sampled again at every transfer boundary, so the device can stop the flow by dropping the line. With edge detection in cycle-steal mode, each transfer needs a fresh rising transition. A programmable count sets the number of transfers. A sticky end flag reports that the count is used up.

Top module: `extreq_seq`

## Requirements
- R1: After reset, req_taken, xfer_start, dev_ack and end_flag are all low.
- R2: The request passes through a two-flop synchronizer. While idle and enabled, req_taken pulses in the third cycle after req_in rises. In level mode a high synchronized level is accepted. In edge mode (edge_mode=1) a low-to-high change between two synchronized samples is accepted.
- R3: The first xfer_start comes LAT_LEVEL (default 4) cycles after req_taken in level mode, and LAT_EDGE (default 5) cycles after it in edge mode.
- R4: In level mode the request is sampled again one cycle after the transfer-done pulse is captured. In cycle-steal mode (burst_mode=0) the next start follows LAT_LEVEL cycles after the new req_taken. In burst mode it comes in the same cycle as that req_taken.
- R5: If the request is low when it is sampled again, no req_taken is issued, no transfer starts and end_flag stays low.
- R6: In edge burst mode req_taken pulses only once. Each following xfer_start comes in the cycle right after the transfer-done pulse is captured, with no new sampling, until the count is used up.
- R7: In edge mode a request that is already high when the channel is enabled is not accepted until it has gone low and risen again.
- R8: In one-address mode (dual_mode=0), dev_ack is high from the xfer_start cycle until eng_done is captured.
- R9: In two-address mode (dual_mode=1), ack_wr_sel=0 places dev_ack in the read half, from xfer_start until eng_rd_done is captured. ack_wr_sel=1 places it in the write half, from the capture of eng_rd_done until the capture of eng_done.
- R10: The count is loaded from xfer_len when the channel leaves idle and drops by one on each captured transfer-done. end_flag rises in the cycle after the last done is captured. It stays high while ch_en is high and clears one cycle after ch_en goes low. A count of zero raises end_flag one cycle after enable, with no transfer.
- R11: Clearing ch_en never cuts a transfer short: dev_ack holds until the engine reports completion. After that, no xfer_start is issued and end_flag stays low.
- R12: req_taken and xfer_start are single-cycle pulses. While ch_en is low at a clock edge, xfer_start is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | 1 | Channel enable |
| edge_mode | input | 1 | 1: rising-edge detection, 0: level detection |
| burst_mode | input | 1 | 1: burst, 0: cycle-steal |
| dual_mode | input | 1 | 1: two-address transfer, 0: one-address transfer |
| ack_wr_sel | input | 1 | Two-address mode: 1 acknowledges in the write half, 0 in the read half |
| xfer_len | input | CNT_W | Number of transfers to run |
| req_in | input | 1 | Asynchronous request from the device |
| eng_rd_done | input | 1 | Engine pulse: read half finished |
| eng_done | input | 1 | Engine pulse: transfer finished |
| req_taken | output | 1 | One-cycle accepted strobe to the device |
| xfer_start | output | 1 | One-cycle start pulse to the engine |
| dev_ack | output | 1 | Per-transfer acknowledge to the device |
| end_flag | output | 1 | Sticky flag: transfer count used up |

## Verification
A wrong state or timer value shows up at the ports quickly, as a shift in the cycle distance between req_taken, xfer_start and the rising edge of dev_ack. The bench measures that distance exactly, so an off-by-one in the latency timer or the synchronizer depth is caught within one transfer. A wrong count shows up as end_flag rising one transfer early or late. A missed sampling decision shows up as an extra or missing accepted strobe, and the scoreboard flags it in the cycle it happens. A phase error in two-address mode moves the acknowledge edge by two cycles within the first transfer.

// File: rtl/extreq_pkg.sv
package extreq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_XFER,
    ST_SAMP,
    ST_END
  } seq_state_e;
endpackage

// File: rtl/extreq_sync.sv
module extreq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic lvl,
  output logic rise
);
  logic [STAGES-1:0] sh_q, sh_n;
  logic              prev_q;

  generate
    if (STAGES > 1) begin : g_chain
      always_comb sh_n = {sh_q[STAGES-2:0], d};
    end else begin : g_single
      always_comb sh_n = d;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl  = sh_q[STAGES-1];
  assign rise = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/extreq_timer.sv
module extreq_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_n;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_n  = load ? ld_val : cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/extreq_count.sv
module extreq_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] cnt_q, cnt_n;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_n  = load ? ld_val : cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  assign last = (cnt_q == W'(1));
endmodule

// File: rtl/extreq_seq.sv
module extreq_seq
  import extreq_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SYNC_STG  = 2,
  parameter int LAT_LEVEL = 4,
  parameter int LAT_EDGE  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ch_en,
  input  logic             edge_mode,
  input  logic             burst_mode,
  input  logic             dual_mode,
  input  logic             ack_wr_sel,
  input  logic [CNT_W-1:0] xfer_len,
  input  logic             req_in,
  input  logic             eng_rd_done,
  input  logic             eng_done,
  output logic             req_taken,
  output logic             xfer_start,
  output logic             dev_ack,
  output logic             end_flag
);
  localparam int LAT_MAX = (LAT_EDGE > LAT_LEVEL) ? LAT_EDGE : LAT_LEVEL;
  localparam int LAT_W   = $clog2(LAT_MAX) + 1;
  localparam logic [LAT_W-1:0] WAIT_LVL = LAT_W'(LAT_LEVEL - 1);
  localparam logic [LAT_W-1:0] WAIT_EDG = LAT_W'(LAT_EDGE - 1);

  seq_state_e st_q, st_n;
  logic       ph_wr_q, ph_wr_n;
  logic       tk_q, tk_n, go_q, go_n, end_q, end_n;
  logic       req_lvl, req_rise, hit;
  logic       t_load, t_zero, c_load, c_dec, c_last;
  logic [LAT_W-1:0] t_val;

  extreq_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(req_in), .lvl(req_lvl), .rise(req_rise)
  );

  extreq_timer #(.W(LAT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .ld_val(t_val), .zero(t_zero)
  );

  extreq_count #(.W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(c_load), .ld_val(xfer_len),
    .dec(c_dec), .last(c_last)
  );

  // Detection variant chosen by the mode bit
  assign hit = edge_mode ? req_rise : req_lvl;

  always_comb begin
    st_n    = st_q;
    ph_wr_n = ph_wr_q;
    tk_n    = 1'b0;
    go_n    = 1'b0;
    end_n   = end_q;
    t_load  = 1'b0;
    t_val   = edge_mode ? WAIT_EDG : WAIT_LVL;
    c_load  = (st_q == ST_IDLE);
    c_dec   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (ch_en) begin
          if (xfer_len == '0) begin
            st_n  = ST_END;
            end_n = 1'b1;
          end else if (hit) begin
            tk_n   = 1'b1;
            t_load = 1'b1;
            st_n   = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (!ch_en) begin
          st_n = ST_IDLE;
        end else if (t_zero) begin
          go_n    = 1'b1;
          ph_wr_n = 1'b0;
          st_n    = ST_XFER;
        end
      end
      ST_XFER: begin
        if (dual_mode && !ph_wr_q && eng_rd_done) ph_wr_n = 1'b1;
        if (eng_done && (!dual_mode || ph_wr_q)) begin
          c_dec = 1'b1;
          if (c_last) begin
            st_n  = ST_END;
            end_n = 1'b1;
          end else if (!ch_en) begin
            st_n = ST_IDLE;
          end else if (edge_mode && burst_mode) begin
            go_n    = 1'b1;
            ph_wr_n = 1'b0;
          end else begin
            st_n = ST_SAMP;
          end
        end
      end
      ST_SAMP: begin
        if (!ch_en) begin
          st_n = ST_IDLE;
        end else if (hit) begin
          tk_n = 1'b1;
          if (burst_mode && !edge_mode) begin
            go_n    = 1'b1;
            ph_wr_n = 1'b0;
            st_n    = ST_XFER;
          end else begin
            t_load = 1'b1;
            st_n   = ST_WAIT;
          end
        end
      end
      ST_END: begin
        if (!ch_en) begin
          st_n  = ST_IDLE;
          end_n = 1'b0;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ph_wr_q <= 1'b0;
      tk_q    <= 1'b0;
      go_q    <= 1'b0;
      end_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      ph_wr_q <= ph_wr_n;
      tk_q    <= tk_n;
      go_q    <= go_n;
      end_q   <= end_n;
    end
  end

  assign req_taken  = tk_q;
  assign xfer_start = go_q;
  assign end_flag   = end_q;
  assign dev_ack    = (st_q == ST_XFER) && (!dual_mode || (ph_wr_q == ack_wr_sel));
endmodule

// File: rtl/extreq_seq_chk.sv
module extreq_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ch_en,
  input logic dual_mode,
  input logic ack_wr_sel,
  input logic eng_rd_done,
  input logic eng_done,
  input logic req_taken,
  input logic xfer_start,
  input logic dev_ack,
  input logic end_flag
);
  a_r12_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);
  a_r12_taken_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_taken |=> !req_taken);
  a_r12_off_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |=> !xfer_start);
  a_r8_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual_mode && xfer_start) |-> dev_ack);
  a_r9_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_mode && !ack_wr_sel && xfer_start) |-> dev_ack);
  a_r9_write_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_mode && ack_wr_sel && xfer_start) |-> !dev_ack);
  a_r10_end_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (end_flag && ch_en) |=> end_flag);
  a_r10_end_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (end_flag && !ch_en) |=> !end_flag);
  a_r10_end_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    end_flag |-> (!dev_ack && !xfer_start));
  a_r11_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack && !eng_done && !eng_rd_done) |=> dev_ack);
endmodule

bind extreq_seq extreq_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .dual_mode(dual_mode),
  .ack_wr_sel(ack_wr_sel), .eng_rd_done(eng_rd_done), .eng_done(eng_done),
  .req_taken(req_taken), .xfer_start(xfer_start), .dev_ack(dev_ack),
  .end_flag(end_flag)
);

// File: tb/sim_extreq_seq.sv
`timescale 1ns/1ps
module sim_extreq_seq;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n, ch_en, edge_mode, burst_mode, dual_mode, ack_wr_sel;
  logic [CW-1:0] xfer_len;
  logic req_in, eng_rd_done, eng_done;
  logic req_taken, xfer_start, dev_ack, end_flag;

  always #10 clk = ~clk;

  extreq_seq #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .edge_mode(edge_mode),
    .burst_mode(burst_mode), .dual_mode(dual_mode), .ack_wr_sel(ack_wr_sel),
    .xfer_len(xfer_len), .req_in(req_in), .eng_rd_done(eng_rd_done),
    .eng_done(eng_done), .req_taken(req_taken), .xfer_start(xfer_start),
    .dev_ack(dev_ack), .end_flag(end_flag)
  );

  // kinds: 0 accepted strobe, 1 start, 2 ack rise, 3 end rise
  typedef struct { int kind; int gap; string tag; } ev_t;
  ev_t   exq[$];
  int    cyc = 0, last_cyc = 0, n_chk = 0, n_fail = 0;
  string quiet_tag = "R1";
  bit    p_ack = 0, p_end = 0, p_start = 0, p_taken = 0;
  bit    finished = 0;

  function automatic string kname(int k);
    case (k)
      0: return "accepted";
      1: return "start";
      2: return "ack-rise";
      default: return "end-rise";
    endcase
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // Bus-cycle engine model
  int  ek = 0;
  bit  eact = 0;
  always @(negedge clk) begin
    eng_rd_done <= 1'b0;
    eng_done    <= 1'b0;
    if (xfer_start) begin
      ek = 0; eact = 1;
    end else if (eact) begin
      ek++;
      if (dual_mode && ek == 1) eng_rd_done <= 1'b1;
      if (ek == (dual_mode ? 3 : 1)) begin
        eng_done <= 1'b1; eact = 0;
      end
    end
  end

  task automatic see(int k);
    ev_t e;
    n_chk++;
    if (exq.size() == 0) begin
      n_fail++;
      $display("FAIL %s: actual %s at cycle %0d, expected no event", quiet_tag, kname(k), cyc);
    end else begin
      e = exq.pop_front();
      if (e.kind != k || (cyc - last_cyc) != e.gap) begin
        n_fail++;
        $display("FAIL %s: actual %s after %0d cycles, expected %s after %0d",
                 e.tag, kname(k), cyc - last_cyc, kname(e.kind), e.gap);
      end
    end
    last_cyc = cyc;
  endtask

  task automatic pulse_chk(bit prev, string what);
    n_chk++;
    if (prev) begin
      n_fail++;
      $display("FAIL R12: %s high for 2 cycles, actual 2 expected 1", what);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished) begin
      if (req_taken) begin pulse_chk(p_taken, "accepted"); see(0); end
      if (xfer_start) begin pulse_chk(p_start, "start"); see(1); end
      if (dev_ack && !p_ack) see(2);
      if (end_flag && !p_end) see(3);
    end
    p_ack   = dev_ack;
    p_end   = end_flag;
    p_start = xfer_start;
    p_taken = req_taken;
  end

  task automatic push(int k, int g, string t);
    ev_t e;
    e.kind = k; e.gap = g; e.tag = t;
    exq.push_back(e);
  endtask

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic settle(string tag);
    for (int i = 0; i < 80 && exq.size() != 0; i++) @(negedge clk);
    chk(exq.size() == 0, tag, "pending expected events", exq.size(), 0);
    exq.delete();
  endtask

  task automatic go_idle();
    ch_en = 0; req_in = 0;
    ticks(8);
  endtask

  task automatic set_mode(bit e, bit b, bit d, bit w, int len);
    edge_mode = e; burst_mode = b; dual_mode = d; ack_wr_sel = w;
    xfer_len = CW'(len);
  endtask

  task automatic anchor_req();
    @(negedge clk);
    ch_en = 1; req_in = 1; last_cyc = cyc;
  endtask

  initial begin
    rst_n = 0; ch_en = 0; req_in = 0;
    set_mode(0, 0, 0, 0, 0);
    ticks(3);
    rst_n = 1;
    ticks(2);
    chk(req_taken == 0, "R1", "req_taken", req_taken, 0);
    chk(xfer_start == 0, "R1", "xfer_start", xfer_start, 0);
    chk(dev_ack == 0, "R1", "dev_ack", dev_ack, 0);
    chk(end_flag == 0, "R1", "end_flag", end_flag, 0);

    // Level, cycle-steal, one-address, two transfers
    quiet_tag = "R4";
    set_mode(0, 0, 0, 0, 2);
    push(0, 3, "R2"); push(1, 4, "R3"); push(2, 0, "R8");
    push(0, 3, "R4"); push(1, 4, "R4"); push(2, 0, "R8"); push(3, 2, "R10");
    anchor_req();
    settle("R4");
    go_idle();

    // Level halt: device drops request after the accepted strobe
    quiet_tag = "R5";
    set_mode(0, 0, 0, 0, 5);
    push(0, 3, "R2"); push(1, 4, "R3"); push(2, 0, "R8");
    anchor_req();
    ticks(3);
    req_in = 0;
    settle("R5");
    ticks(20);
    chk(end_flag == 0, "R5", "end_flag after halt", end_flag, 0);
    go_idle();

    // Edge burst, two-address, ack in read half, three transfers
    quiet_tag = "R6";
    set_mode(1, 1, 1, 0, 3);
    push(0, 3, "R2"); push(1, 5, "R3"); push(2, 0, "R9");
    push(1, 4, "R6"); push(2, 0, "R9"); push(1, 4, "R6"); push(2, 0, "R9");
    push(3, 4, "R10");
    anchor_req();
    settle("R6");
    go_idle();

    // Edge burst, two-address, ack in write half, two transfers
    quiet_tag = "R9";
    set_mode(1, 1, 1, 1, 2);
    push(0, 3, "R2"); push(1, 5, "R3"); push(2, 2, "R9");
    push(1, 2, "R6"); push(2, 2, "R9"); push(3, 2, "R10");
    anchor_req();
    settle("R9");
    go_idle();

    // Level burst, one-address, three transfers
    quiet_tag = "R4";
    set_mode(0, 1, 0, 0, 3);
    push(0, 3, "R2"); push(1, 4, "R3"); push(2, 0, "R8");
    push(0, 3, "R4"); push(1, 0, "R4"); push(2, 0, "R8");
    push(0, 3, "R4"); push(1, 0, "R4"); push(2, 0, "R8");
    push(3, 2, "R10");
    anchor_req();
    settle("R4");
    go_idle();

    // Disable during a transfer
    quiet_tag = "R11";
    set_mode(0, 0, 0, 0, 5);
    push(0, 3, "R2"); push(1, 4, "R3"); push(2, 0, "R8");
    anchor_req();
    for (int i = 0; i < 40 && !xfer_start; i++) @(negedge clk);
    ch_en = 0;
    ticks(1);
    chk(dev_ack == 1, "R11", "dev_ack mid-transfer after disable", dev_ack, 1);
    settle("R11");
    ticks(20);
    chk(end_flag == 0, "R11", "end_flag after abort", end_flag, 0);
    go_idle();

    // Zero count
    quiet_tag = "R10";
    set_mode(0, 0, 0, 0, 0);
    push(3, 1, "R10");
    @(negedge clk);
    ch_en = 1; last_cyc = cyc;
    settle("R10");
    ticks(5);
    chk(end_flag == 1, "R10", "end_flag sticky", end_flag, 1);
    ch_en = 0;
    ticks(1);
    chk(end_flag == 0, "R10", "end_flag after disable", end_flag, 0);
    go_idle();

    // Edge mode with request already high at enable
    quiet_tag = "R7";
    set_mode(1, 0, 0, 0, 1);
    req_in = 1;
    ticks(5);
    ch_en = 1;
    ticks(15);
    chk(req_taken == 0, "R7", "req_taken on static high", req_taken, 0);
    req_in = 0;
    ticks(4);
    push(0, 3, "R7"); push(1, 5, "R3"); push(2, 0, "R8"); push(3, 2, "R10");
    @(negedge clk);
    req_in = 1; last_cyc = cyc;
    settle("R7");
    go_idle();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule